// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a tag-to-reader response that has no start marker, no stop marker and no length field. When the reader has finished sending, a start strobe arms the block. The block then waits a fixed turnaround time. After that it splits time into equal bit slots. In each slot it counts the level changes on a digitised receive input. A slot whose count falls inside an open window reads as a 1, because the tag's subcarrier is present. Any other count, whether too few or too many, reads as a 0.

The caller supplies the number of bits to expect with every start. Bits are packed least-significant first into a 32-bit word. The caller can also supply a keystream and a decrypt enable; when the enable is set, the packed word is XORed with the keystream before it is reported. The result appears on a word output with a one-cycle valid strobe and stays there until the next frame completes.

All times are counted in clock cycles and set by parameters. The defaults model a 330-unit turnaround and 100-unit slots at two clocks per unit of the time scale used here.

Top module: `slot_edge_demod`

## Requirements
- R1: While reset is asserted and after it is released, `word_o` is 0 and `valid_o` and `busy_o` are 0 until a start is accepted.
- R2: A start strobe taken while idle raises `busy_o` on the next cycle. The block waits `TURN_CYC` cycles and then runs N slots of `SLOT_CYC` cycles each. `valid_o` is high exactly `TURN_CYC + N*SLOT_CYC` clock edges after the edge that sampled the start, and `busy_o` falls on that same edge.
- R3: A slot decodes as 1 when its edge count is greater than `ONE_MIN` (20) and less than `ONE_MAX` (60). A count of 20 or 60 decodes as 0, and a count of 21 or 59 decodes as 1.
- R4: An edge is any change, rising or falling, of the receive level after a two-flop synchroniser. Each slot counts from zero, and edges seen during the turnaround wait are not counted.
- R5: The per-slot edge counter saturates at 127 and does not wrap, so a slot with 160 edges decodes as 0.
- R6: Slot k, counted from 0, sets bit k of the word (least-significant first). Bits at position N and above are 0.
- R7: The bit count is sampled at start. A value above 32 is treated as 32.
- R8: When the decrypt enable sampled at start is 1, the word is the decoded bits XOR the keystream sampled at start, with the keystream masked to N bits. When the enable is 0, no XOR is applied.
- R9: `valid_o` is high for one cycle only. `word_o` changes only on that cycle and otherwise holds its value, even while the receive input keeps toggling.
- R10: A start strobe while `busy_o` is high is ignored. The frame in progress keeps its timing, bit count, key and enable.
- R11: A bit count of 0 ends the frame after the turnaround wait alone, and the word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe marking the end of the reader frame |
| bit_count_i | input | 7 | Number of bits expected (clamped to 32) |
| decrypt_en_i | input | 1 | Apply the keystream XOR to this frame |
| keystream_i | input | 32 | Keystream bits, LSB applies to the first slot |
| rx_level_i | input | 1 | Digitised receive level, asynchronous |
| word_o | output | 32 | Decoded word, LSB first |
| valid_o | output | 1 | One-cycle strobe when `word_o` updates |
| busy_o | output | 1 | High from the cycle after an accepted start until the frame ends |

## Verification
Each frame is built slot by slot from a bit pattern. A 1 slot gets a burst of toggles near the nominal 42 and a 0 slot gets either silence or a small burst of noise. Mixed nibble patterns at several lengths, one above the clamp, separate LSB-first packing from reversed or shifted packing, and keyed frames show whether the keystream mask follows the bit count. Single-bit frames with 20, 21, 59, 60 and 160 edges test both sides of each window edge and the difference between saturation and wrap. A second start part-way through a frame, with every other input changed, shows whether the in-flight frame keeps its captured settings. A zero-length frame tests the bare turnaround path.

// File: rtl/slot_demod_pkg.sv
package slot_demod_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TURN = 2'd1,
        PH_SLOT = 2'd2
    } phase_e;

endpackage

// File: rtl/sd_level_sync.sv
// Synchronises the asynchronous receive level and flags any change of it.
module sd_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], level_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign edge_o = s_q.chain[STAGES-1] ^ s_q.prev;
endmodule

// File: rtl/sd_edge_tally.sv
// Saturating per-slot edge counter and window decision.
module sd_edge_tally #(
    parameter int ONE_MIN = 20,
    parameter int ONE_MAX = 60,
    parameter int CNT_W   = $clog2(ONE_MAX) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en_i,
    input  logic slot_last_i,
    input  logic edge_i,
    output logic bit_o
);
    localparam logic [CNT_W:0] SAT_VAL = (CNT_W+1)'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;

    always_comb begin
        sum = {1'b0, cnt_q} + (CNT_W+1)'(count_en_i & edge_i);
        sat = (sum > SAT_VAL) ? SAT_VAL[CNT_W-1:0] : sum[CNT_W-1:0];
        if (!count_en_i || slot_last_i) cnt_d = '0;
        else                            cnt_d = sat;
        bit_o = (sat > CNT_W'(ONE_MIN)) && (sat < CNT_W'(ONE_MAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sd_phase_timer.sv
// Cycle counter for the turnaround wait and for each bit slot.
module sd_phase_timer #(
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [TMR_W-1:0] count_o
);
    logic [TMR_W-1:0] t_d, t_q;

    always_comb begin
        t_d = clr_i ? '0 : t_q + TMR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign count_o = t_q;
endmodule

// File: rtl/slot_edge_demod.sv
module slot_edge_demod
    import slot_demod_pkg::*;
#(
    parameter int TURN_CYC = 660,
    parameter int SLOT_CYC = 200,
    parameter int ONE_MIN  = 20,
    parameter int ONE_MAX  = 60,
    parameter int MAX_BITS = 32,
    parameter int SYNC_STG = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [$clog2(MAX_BITS+1):0]       bit_count_i,
    input  logic                              decrypt_en_i,
    input  logic [MAX_BITS-1:0]               keystream_i,
    input  logic                              rx_level_i,
    output logic [MAX_BITS-1:0]               word_o,
    output logic                              valid_o,
    output logic                              busy_o
);
    localparam int BC_W   = $clog2(MAX_BITS+1) + 1;
    localparam int NB_W   = $clog2(MAX_BITS+1);
    localparam int IDX_W  = $clog2(MAX_BITS);
    localparam int TMR_MX = (TURN_CYC > SLOT_CYC) ? TURN_CYC : SLOT_CYC;
    localparam int TMR_W  = $clog2(TMR_MX + 1);
    localparam int CNT_W  = $clog2(ONE_MAX) + 1;

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [NB_W-1:0]     nbits;
        logic [MAX_BITS-1:0] key;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] word;
        logic                valid;
    } st_t;

    st_t s_d, s_q;

    logic             rx_edge;
    logic             slot_bit;
    logic [TMR_W-1:0] tmr;
    logic             tmr_clr;
    logic             turn_end;
    logic             slot_end;
    logic [NB_W-1:0]  nb_clamped;
    logic [MAX_BITS-1:0] nb_mask;
    logic [MAX_BITS-1:0] acc_next;

    sd_level_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (rx_level_i),
        .edge_o  (rx_edge)
    );

    sd_edge_tally #(.ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX), .CNT_W(CNT_W)) u_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_en_i  (s_q.phase == PH_SLOT),
        .slot_last_i (slot_end),
        .edge_i      (rx_edge),
        .bit_o       (slot_bit)
    );

    sd_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .count_o (tmr)
    );

    always_comb begin
        turn_end = (s_q.phase == PH_TURN) && (tmr == TMR_W'(TURN_CYC - 1));
        slot_end = (s_q.phase == PH_SLOT) && (tmr == TMR_W'(SLOT_CYC - 1));
        tmr_clr  = (s_q.phase == PH_IDLE) || turn_end || slot_end;

        if (bit_count_i > BC_W'(MAX_BITS)) nb_clamped = NB_W'(MAX_BITS);
        else                               nb_clamped = bit_count_i[NB_W-1:0];

        if (nb_clamped >= NB_W'(MAX_BITS)) nb_mask = '1;
        else nb_mask = (MAX_BITS'(1) << nb_clamped) - MAX_BITS'(1);

        acc_next = s_q.acc | (MAX_BITS'(slot_bit) << s_q.idx);

        s_d       = s_q;
        s_d.valid = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_TURN;
                    s_d.nbits = nb_clamped;
                    s_d.key   = decrypt_en_i ? (keystream_i & nb_mask) : '0;
                    s_d.acc   = '0;
                    s_d.idx   = '0;
                end
            end
            PH_TURN: begin
                if (turn_end) begin
                    if (s_q.nbits == '0) begin
                        s_d.phase = PH_IDLE;
                        s_d.word  = '0;
                        s_d.valid = 1'b1;
                    end else begin
                        s_d.phase = PH_SLOT;
                    end
                end
            end
            PH_SLOT: begin
                if (slot_end) begin
                    s_d.acc = acc_next;
                    if (NB_W'(s_q.idx) == s_q.nbits - NB_W'(1)) begin
                        s_d.phase = PH_IDLE;
                        s_d.word  = acc_next ^ s_q.key;
                        s_d.valid = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o  = s_q.word;
    assign valid_o = s_q.valid;
    assign busy_o  = (s_q.phase != PH_IDLE);
endmodule

// File: rtl/slot_edge_demod_chk.sv
module slot_edge_demod_chk #(
    parameter int MAX_BITS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [MAX_BITS-1:0] word_o,
    input logic                valid_o,
    input logic                busy_o
);
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(word_o));

    // R2
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o);

    // R2
    fall_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $fell(busy_o));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy_o) |=> !busy_o);
endmodule

bind slot_edge_demod slot_edge_demod_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .word_o  (word_o),
    .valid_o (valid_o),
    .busy_o  (busy_o)
);

// File: tb/slot_edge_demod_tb.sv
module slot_edge_demod_tb;
    localparam int TURN = 660;
    localparam int SLOT = 200;
    localparam int OFS  = 20;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic [6:0]  bit_count_i = 0;
    logic        decrypt_en_i = 0;
    logic [31:0] keystream_i = 0;
    logic        rx_level_i = 0;
    logic [31:0] word_o;
    logic        valid_o;
    logic        busy_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    slot_edge_demod u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .bit_count_i  (bit_count_i),
        .decrypt_en_i (decrypt_en_i),
        .keystream_i  (keystream_i),
        .rx_level_i   (rx_level_i),
        .word_o       (word_o),
        .valid_o      (valid_o),
        .busy_o       (busy_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Runs one frame; glitch_t >= 0 issues a second start with altered inputs.
    task automatic run_frame(input string req, input logic [6:0] nb, input logic [31:0] pat,
                             input logic [31:0] key, input logic en, input int e1,
                             input int e0, input int glitch_t);
        int nc;
        int total;
        int early;
        logic [31:0] mask;
        logic [31:0] exp;
        nc    = (nb > 7'd32) ? 32 : int'(nb);
        total = TURN + nc * SLOT;
        mask  = (nc >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nc) - 32'd1);
        exp   = (pat ^ (en ? key : 32'd0)) & mask;
        early = 0;
        @(negedge clk);
        bit_count_i  = nb;
        keystream_i  = key;
        decrypt_en_i = en;
        start_i      = 1;
        @(negedge clk);
        start_i = 0;
        for (int t = 0; t <= total; t++) begin
            if (t > 0) @(negedge clk);
            if (t < total && valid_o) early++;
            if (t == total) begin
                chk({req, " valid at slot count"}, {31'd0, valid_o}, 32'd1);
                chk({req, " word"}, word_o, exp);
            end
            start_i = (t == glitch_t);
            if (t == glitch_t) begin
                bit_count_i  = 7'd1;
                keystream_i  = ~key;
                decrypt_en_i = ~en;
            end
            if (t >= TURN && t < total) begin
                int u;
                int slot;
                int off;
                int cnt;
                u    = t - TURN;
                slot = u / SLOT;
                off  = u % SLOT;
                cnt  = pat[slot] ? e1 : e0;
                if (off >= OFS && off < OFS + cnt) rx_level_i = ~rx_level_i;
            end
        end
        chk({req, " no early valid"}, early, 0);
        @(negedge clk);
        chk("R9 one-cycle valid", {30'd0, valid_o, busy_o}, 32'd0);
    endtask

    typedef struct packed {
        logic [6:0]  nb;
        logic [31:0] pat;
        logic [31:0] key;
        logic        en;
        logic [7:0]  e1;
        logic [7:0]  e0;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{7'd6,  32'h0000_002D, 32'h0000_0000, 1'b0, 8'd42, 8'd0},
        '{7'd12, 32'h0000_0A5C, 32'h0000_3F0F, 1'b1, 8'd42, 8'd3},
        '{7'd32, 32'hDEAD_BEEF, 32'h0000_0000, 1'b0, 8'd30, 8'd10},
        '{7'd40, 32'h1234_5678, 32'hFFFF_0000, 1'b1, 8'd50, 8'd0},
        '{7'd7,  32'h0000_0055, 32'h0000_0000, 1'b0, 8'd22, 8'd18},
        '{7'd1,  32'h0000_0001, 32'h0000_0001, 1'b1, 8'd42, 8'd0}
    };

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset word", word_o, 32'd0);
        chk("R1 reset flags", {30'd0, valid_o, busy_o}, 32'd0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R1 idle after reset", {word_o[29:0], valid_o, busy_o}, 32'd0);

        // R2 R3 R4 R6 R7 R8 table of frames
        for (int i = 0; i < 6; i++) begin
            run_frame($sformatf("R6 R7 R8 vec%0d", i), VECS[i].nb, VECS[i].pat, VECS[i].key,
                      VECS[i].en, int'(VECS[i].e1), int'(VECS[i].e0), -1);
        end

        // R3 window boundaries, single-bit frames
        run_frame("R3 count20", 7'd1, 32'd0, 32'd0, 1'b0, 0, 20, -1);
        run_frame("R3 count21", 7'd1, 32'd1, 32'd0, 1'b0, 21, 0, -1);
        run_frame("R3 count59", 7'd1, 32'd1, 32'd0, 1'b0, 59, 0, -1);
        run_frame("R3 count60", 7'd1, 32'd0, 32'd0, 1'b0, 0, 60, -1);
        // R5 saturation: 160 edges would alias to 32 if wrapped
        run_frame("R5 count160", 7'd1, 32'd0, 32'd0, 1'b0, 0, 160, -1);

        // R4 edges during the turnaround are not counted
        run_frame("R4 edges in slot only", 7'd2, 32'h2, 32'd0, 1'b0, 42, 0, -1);

        // R10 second start mid-frame is ignored
        run_frame("R10 busy start", 7'd8, 32'h0000_00B4, 32'h0000_00FF, 1'b1, 42, 0, TURN + 350);

        // R11 zero-length frame
        run_frame("R11 zero bits", 7'd0, 32'd0, 32'hFFFF_FFFF, 1'b1, 42, 0, -1);

        // R9 word holds while idle with a toggling input
        run_frame("R9 setup", 7'd4, 32'h9, 32'd0, 1'b0, 42, 0, -1);
        held = word_o;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            rx_level_i = ~rx_level_i;
        end
        chk("R9 word holds", word_o, held);
        chk("R9 no valid while idle", {30'd0, valid_o, busy_o}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule